// File: doc/BRIEF.md
# CPU Pixel Coordinate Address Translator

This block sits on the path from a CPU memory bus to a linear frame-buffer RAM. A CPU access whose top address nibble matches the video window tag is read as a pixel coordinate. The 12 bits below the tag give the line number Y and the low 16 bits give the column X. The block turns the pair into a dense row-major frame-buffer address `Y*640 + X` and forwards the read or write with its 16-bit pixel value. Software can then place a pixel by writing its coordinates straight into an address, with no row-offset arithmetic. Every other access goes to the ordinary memory port unchanged.

The request, translated address, write data and write strobe are registered once, so the RAM port sees an access one cycle after the CPU presents it. Window reads come back to the CPU with a valid strobe that allows for this register and for the RAM's own read latency. A window access with a coordinate outside the 640x480 raster never reaches the RAM. In that case a write is discarded, a read returns zero, and a sticky flag records the event. The scan-out side reads the same RAM as a plain linear bitmap.

Top module: `pixaddr_xlate`

## Requirements
- R1: After a synchronous reset, `fb_en`, `fb_we`, `mem_req`, `mem_we`, `cpu_rvalid` and `oor_flag` are all 0.
- R2: A request with `cpu_addr[31:28] == 4'h8` takes the frame-buffer path, and any other request takes the memory path. `fb_en` and `mem_req` are never high in the same cycle.
- R3: Inside the window, Y is `cpu_addr[27:16]` and X is `cpu_addr[15:0]`. `fb_addr` equals `Y*640 + X`, and it is always below 307200 while `fb_en` is high.
- R4: An in-range window request drives `fb_en`, `fb_we` (equal to `cpu_we`), `fb_addr` and `fb_wdata` in the cycle after it is presented, each for exactly one cycle.
- R5: A request outside the window drives `mem_req` in the cycle after it is presented, with `mem_addr`, `mem_we` and `mem_wdata` equal to the CPU values. `fb_en` stays low.
- R6: A window write with X ≥ 640 or Y ≥ 480 raises neither `fb_en` nor `mem_req`.
- R7: A window read with X ≥ 640 or Y ≥ 480 raises no RAM access. It still returns `cpu_rvalid` with `cpu_rdata = 0`, at the same latency as an in-range read.
- R8: An in-range window read pulses `cpu_rvalid` for one cycle, RAM_LAT+1 cycles after its `fb_en` cycle. With RAM_LAT=1 that is the third cycle after the request. The pulse carries the `fb_rdata` value that the RAM returned for that address.
- R9: `oor_flag` rises in the cycle after the first out-of-range window access. It stays high through all later accesses until reset.
- R10: The corner coordinates map exactly: (0,0) goes to address 0, (639,0) to 639, (0,1) to 640, and (639,479) to 307199.
- R11: Writes and accesses outside the window never produce `cpu_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | CPU access request, one cycle per access |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte-free word address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | Pixel read data returned for window reads |
| cpu_rvalid | output | 1 | One-cycle strobe qualifying `cpu_rdata` |
| fb_en | output | 1 | Frame-buffer access enable |
| fb_we | output | 1 | Frame-buffer write strobe |
| fb_addr | output | 19 | Linear frame-buffer address |
| fb_wdata | output | 16 | Frame-buffer write data |
| fb_rdata | input | 16 | Frame-buffer read data, RAM_LAT cycles after `fb_en` |
| mem_req | output | 1 | Ordinary memory access request |
| mem_we | output | 1 | Ordinary memory write strobe |
| mem_addr | output | 32 | Ordinary memory address, passed through |
| mem_wdata | output | 16 | Ordinary memory write data |
| oor_flag | output | 1 | Sticky out-of-range coordinate flag |

## Verification
The bench targets the raster edges: X of 639 against 640, Y of 479 against 480, and X values far past the line width that still sit in the window. If the range check is off by one, an edge pixel is either dropped or written into the first pixel of the next line. If the shift-add is wrong, (0,1) no longer lands on 640. Addresses next to the window tag (0x7FFF_FFFF and 0x9000_0000) are sent to confirm that the window decode neither leaks into nor steals from ordinary memory. Read strobes are checked one cycle early, on time and one cycle late, so a miscounted read pipeline would return stale data or a doubled pulse. A zero-returning out-of-range read that still touched the RAM would show up as a stray `fb_en`.

// File: rtl/pxl_pkg.sv
package pxl_pkg;

  // Routing decision for one CPU request
  typedef enum logic [1:0] {
    PATH_IDLE = 2'd0,
    PATH_FB   = 2'd1,
    PATH_MEM  = 2'd2,
    PATH_DROP = 2'd3
  } path_e;

  // Read-return tag carried down the latency pipe
  typedef struct packed {
    logic vld;
    logic zero;
  } rtag_t;

endpackage

// File: rtl/pxl_window_decode.sv
module pxl_window_decode
  import pxl_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TAG_W   = 4,
  parameter int WIN_TAG = 8,
  parameter int H_RES   = 640,
  parameter int V_RES   = 480,
  localparam int HALF   = ADDR_W / 2,
  localparam int Y_W    = HALF - TAG_W,
  localparam int X_W    = HALF
) (
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output path_e             path,
  output logic [Y_W-1:0]    y,
  output logic [X_W-1:0]    x
);

  localparam logic [TAG_W-1:0] TAG_V = TAG_W'(WIN_TAG);
  localparam logic [X_W-1:0]   X_LIM = X_W'(H_RES);
  localparam logic [Y_W-1:0]   Y_LIM = Y_W'(V_RES);

  logic in_win;
  logic in_raster;

  assign in_win    = (addr[ADDR_W-1 -: TAG_W] == TAG_V);
  assign y         = addr[ADDR_W-TAG_W-1 : HALF];
  assign x         = addr[HALF-1:0];
  assign in_raster = (x < X_LIM) && (y < Y_LIM);

  always_comb begin
    if (!req)            path = PATH_IDLE;
    else if (!in_win)    path = PATH_MEM;
    else if (in_raster)  path = PATH_FB;
    else                 path = PATH_DROP;
  end

endmodule

// File: rtl/pxl_linearize.sv
module pxl_linearize #(
  parameter int Y_W   = 12,
  parameter int X_W   = 16,
  parameter int H_RES = 640,
  parameter int FB_AW = 19
) (
  input  logic [Y_W-1:0]   y,
  input  logic [X_W-1:0]   x,
  output logic [FB_AW-1:0] lin
);

  logic [FB_AW-1:0] y_ext;
  logic [FB_AW-1:0] x_ext;
  logic [FB_AW-1:0] row_base;

  assign y_ext = FB_AW'(y);
  assign x_ext = FB_AW'(x);

  generate
    if (H_RES == 640) begin : g_shift_add
      // 640 = 512 + 128: two shifted copies, no multiplier
      assign row_base = (y_ext << 9) + (y_ext << 7);
    end else begin : g_mult
      localparam logic [FB_AW-1:0] H_V = FB_AW'(H_RES);
      assign row_base = y_ext * H_V;
    end
  endgenerate

  assign lin = row_base + x_ext;

endmodule

// File: rtl/pxl_read_return.sv
module pxl_read_return
  import pxl_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int RAM_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  rtag_t             issue,
  input  logic [DATA_W-1:0] ram_rdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);

  logic [RAM_LAT:0] vld_sr;
  logic [RAM_LAT:0] zero_sr;
  logic             vld_tail;
  logic             zero_tail;

  generate
    if (RAM_LAT == 0) begin : g_no_lat
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_sr  <= '0;
          zero_sr <= '0;
        end else begin
          vld_sr  <= issue.vld;
          zero_sr <= issue.zero;
        end
      end
    end else begin : g_lat
      always_ff @(posedge clk) begin
        if (rst) begin
          vld_sr  <= '0;
          zero_sr <= '0;
        end else begin
          vld_sr  <= {vld_sr[RAM_LAT-1:0], issue.vld};
          zero_sr <= {zero_sr[RAM_LAT-1:0], issue.zero};
        end
      end
    end
  endgenerate

  assign vld_tail  = vld_sr[RAM_LAT];
  assign zero_tail = zero_sr[RAM_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= vld_tail;
      if (vld_tail) rdata <= zero_tail ? '0 : ram_rdata;
    end
  end

endmodule

// File: rtl/pixaddr_xlate.sv
module pixaddr_xlate
  import pxl_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 4,
  parameter int WIN_TAG = 8,
  parameter int H_RES   = 640,
  parameter int V_RES   = 480,
  parameter int FB_AW   = 19,
  parameter int RAM_LAT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_rvalid,
  output logic              fb_en,
  output logic              fb_we,
  output logic [FB_AW-1:0]  fb_addr,
  output logic [DATA_W-1:0] fb_wdata,
  input  logic [DATA_W-1:0] fb_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              oor_flag
);

  localparam int HALF = ADDR_W / 2;
  localparam int Y_W  = HALF - TAG_W;
  localparam int X_W  = HALF;

  path_e            path;
  logic [Y_W-1:0]   coord_y;
  logic [X_W-1:0]   coord_x;
  logic [FB_AW-1:0] lin_addr;
  rtag_t            rd_issue;

  pxl_window_decode #(
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W),
    .WIN_TAG(WIN_TAG),
    .H_RES  (H_RES),
    .V_RES  (V_RES)
  ) u_decode (
    .req (cpu_req),
    .addr(cpu_addr),
    .path(path),
    .y   (coord_y),
    .x   (coord_x)
  );

  pxl_linearize #(
    .Y_W  (Y_W),
    .X_W  (X_W),
    .H_RES(H_RES),
    .FB_AW(FB_AW)
  ) u_lin (
    .y  (coord_y),
    .x  (coord_x),
    .lin(lin_addr)
  );

  assign rd_issue.vld  = !cpu_we && ((path == PATH_FB) || (path == PATH_DROP));
  assign rd_issue.zero = (path == PATH_DROP);

  pxl_read_return #(
    .DATA_W (DATA_W),
    .RAM_LAT(RAM_LAT)
  ) u_ret (
    .clk      (clk),
    .rst      (rst),
    .issue    (rd_issue),
    .ram_rdata(fb_rdata),
    .rvalid   (cpu_rvalid),
    .rdata    (cpu_rdata)
  );

  // Frame-buffer side register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      fb_en    <= 1'b0;
      fb_we    <= 1'b0;
      fb_addr  <= '0;
      fb_wdata <= '0;
    end else begin
      fb_en <= (path == PATH_FB);
      fb_we <= (path == PATH_FB) && cpu_we;
      if (path == PATH_FB) begin
        fb_addr  <= lin_addr;
        fb_wdata <= cpu_wdata;
      end
    end
  end

  // Ordinary memory side register stage
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req <= (path == PATH_MEM);
      mem_we  <= (path == PATH_MEM) && cpu_we;
      if (path == PATH_MEM) begin
        mem_addr  <= cpu_addr;
        mem_wdata <= cpu_wdata;
      end
    end
  end

  // Sticky out-of-range indication
  always_ff @(posedge clk) begin
    if (rst)                    oor_flag <= 1'b0;
    else if (path == PATH_DROP) oor_flag <= 1'b1;
  end

endmodule

// File: rtl/pxl_xlate_checker.sv
module pxl_xlate_checker #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 4,
  parameter int WIN_TAG = 8,
  parameter int H_RES   = 640,
  parameter int V_RES   = 480,
  parameter int FB_AW   = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rvalid,
  input logic              fb_en,
  input logic              fb_we,
  input logic [FB_AW-1:0]  fb_addr,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              oor_flag
);

  localparam int HALF = ADDR_W / 2;
  localparam logic [FB_AW-1:0] PIX_TOTAL = FB_AW'(H_RES * V_RES);

  logic win_hit;
  logic on_raster;

  assign win_hit   = (int'(cpu_addr[ADDR_W-1 -: TAG_W]) == WIN_TAG);
  assign on_raster = (int'(cpu_addr[HALF-1:0]) < H_RES) &&
                     (int'(cpu_addr[ADDR_W-TAG_W-1:HALF]) < V_RES);

  AST_PATH_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(fb_en && mem_req));  // R2

  AST_FB_IN_RASTER: assert property (@(posedge clk) disable iff (rst)
    fb_en |-> (fb_addr < PIX_TOTAL));  // R3

  AST_FB_NEXT_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && win_hit && on_raster) |=> (fb_en && (fb_we == $past(cpu_we)) && !mem_req));  // R4

  AST_MEM_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && !win_hit) |=> (mem_req && !fb_en && (mem_addr == $past(cpu_addr))));  // R5

  AST_OOR_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && win_hit && !on_raster) |=> (!fb_en && !mem_req));  // R6

  AST_OOR_STICKY: assert property (@(posedge clk) disable iff (rst)
    oor_flag |=> oor_flag);  // R9

  AST_OOR_SETS: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && win_hit && !on_raster) |=> oor_flag);  // R9

  AST_NO_IDLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    !cpu_req |=> (!fb_en && !mem_req));  // R2

  AST_FB_WE_QUAL: assert property (@(posedge clk) disable iff (rst)
    fb_we |-> fb_en);  // R4

  AST_RVALID_BOOL: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(cpu_rvalid));  // R8

endmodule

bind pixaddr_xlate pxl_xlate_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .TAG_W  (TAG_W),
  .WIN_TAG(WIN_TAG),
  .H_RES  (H_RES),
  .V_RES  (V_RES),
  .FB_AW  (FB_AW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_addr  (cpu_addr),
  .cpu_rvalid(cpu_rvalid),
  .fb_en     (fb_en),
  .fb_we     (fb_we),
  .fb_addr   (fb_addr),
  .mem_req   (mem_req),
  .mem_addr  (mem_addr),
  .oor_flag  (oor_flag)
);

// File: tb/pixaddr_xlate_test.sv
module pixaddr_xlate_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_req;
  logic        cpu_we;
  logic [31:0] cpu_addr;
  logic [15:0] cpu_wdata;
  logic [15:0] cpu_rdata;
  logic        cpu_rvalid;
  logic        fb_en;
  logic        fb_we;
  logic [18:0] fb_addr;
  logic [15:0] fb_wdata;
  logic [15:0] fb_rdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        oor_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit oor_seen = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pixaddr_xlate uut (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .fb_en(fb_en), .fb_we(fb_we), .fb_addr(fb_addr), .fb_wdata(fb_wdata),
    .fb_rdata(fb_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .oor_flag(oor_flag)
  );

  // Frame-buffer RAM model: one-cycle synchronous read of an address pattern
  function automatic logic [15:0] ram_word(input logic [18:0] a);
    return a[15:0] ^ {a[18:16], 13'h0} ^ 16'h5A3C;
  endfunction

  always_ff @(posedge clk) begin
    if (fb_en && !fb_we) fb_rdata <= ram_word(fb_addr);
  end

  function automatic bit in_win(input logic [31:0] a);
    return a[31:28] == 4'h8;
  endfunction

  function automatic bit in_raster(input logic [31:0] a);
    return (a[15:0] < 16'd640) && (a[27:16] < 12'd480);
  endfunction

  function automatic logic [18:0] lin_of(input logic [31:0] a);
    int v;
    v = int'(a[27:16]) * 640 + int'(a[15:0]);
    return v[18:0];
  endfunction

  function automatic logic [31:0] xy(input int x, input int y);
    logic [31:0] r;
    r = {4'h8, 12'(y), 16'(x)};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // One access, checked over the following cycles
  task automatic access(input bit we, input logic [31:0] a, input logic [15:0] wd);
    bit win, ok_r, rd;
    win  = in_win(a);
    ok_r = in_raster(a);
    rd   = win && !we;
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    if (!win) begin
      chk(mem_req == 1'b1, "R5", "mem_req", 32'(mem_req), 1);
      chk(mem_addr == a, "R5", "mem_addr", mem_addr, a);
      chk(mem_we == we, "R5", "mem_we", 32'(mem_we), 32'(we));
      if (we) chk(mem_wdata == wd, "R5", "mem_wdata", 32'(mem_wdata), 32'(wd));
      chk(fb_en == 1'b0, "R2", "fb_en on memory path", 32'(fb_en), 0);
    end else if (ok_r) begin
      chk(fb_en == 1'b1, "R4", "fb_en", 32'(fb_en), 1);
      chk(fb_we == we, "R4", "fb_we", 32'(fb_we), 32'(we));
      chk(fb_addr == lin_of(a), "R3", "fb_addr", 32'(fb_addr), 32'(lin_of(a)));
      if (we) chk(fb_wdata == wd, "R4", "fb_wdata", 32'(fb_wdata), 32'(wd));
      chk(mem_req == 1'b0, "R2", "mem_req on window path", 32'(mem_req), 0);
    end else begin
      chk(fb_en == 1'b0 && mem_req == 1'b0, "R6", "dropped access strobes",
          {30'd0, fb_en, mem_req}, 0);
      oor_seen = 1'b1;
    end
    chk(oor_flag == oor_seen, "R9", "oor_flag", 32'(oor_flag), 32'(oor_seen));
    @(negedge clk);
    chk(cpu_rvalid == 1'b0, rd ? "R8" : "R11", "early rvalid", 32'(cpu_rvalid), 0);
    chk(fb_en == 1'b0, "R4", "fb_en single cycle", 32'(fb_en), 0);
    @(negedge clk);
    if (rd) begin
      logic [15:0] exp_d;
      exp_d = ok_r ? ram_word(lin_of(a)) : 16'h0;
      chk(cpu_rvalid == 1'b1, ok_r ? "R8" : "R7", "rvalid", 32'(cpu_rvalid), 1);
      chk(cpu_rdata == exp_d, ok_r ? "R8" : "R7", "rdata", 32'(cpu_rdata), 32'(exp_d));
      @(negedge clk);
      chk(cpu_rvalid == 1'b0, "R8", "rvalid single cycle", 32'(cpu_rvalid), 0);
    end else begin
      chk(cpu_rvalid == 1'b0, "R11", "rvalid after write or memory access",
          32'(cpu_rvalid), 0);
    end
    chk(oor_flag == oor_seen, "R9", "oor_flag hold", 32'(oor_flag), 32'(oor_seen));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    fb_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({fb_en, fb_we, mem_req, mem_we, cpu_rvalid, oor_flag} == 6'b0, "R1",
        "reset outputs", {26'd0, fb_en, fb_we, mem_req, mem_we, cpu_rvalid, oor_flag}, 0);

    // R10 corner coordinates, writes then reads
    access(1'b1, xy(0, 0), 16'h1111);
    chk(fb_addr == 19'd0, "R10", "origin address", 32'(fb_addr), 0);
    access(1'b1, xy(639, 0), 16'h2222);
    chk(fb_addr == 19'd639, "R10", "end of first line", 32'(fb_addr), 639);
    access(1'b1, xy(0, 1), 16'h3333);
    chk(fb_addr == 19'd640, "R10", "start of second line", 32'(fb_addr), 640);
    access(1'b1, xy(639, 479), 16'h4444);
    chk(fb_addr == 19'd307199, "R10", "last pixel", 32'(fb_addr), 307199);
    access(1'b0, xy(639, 479), 16'h0);
    access(1'b0, xy(0, 1), 16'h0);

    // R2 window boundaries
    access(1'b1, 32'h7FFF_FFFF, 16'hABCD);
    access(1'b0, 32'h9000_0000, 16'h0);
    access(1'b1, 32'h8000_0000, 16'h5555);

    // R6 R7 out-of-range edges, then the flag must hold (R9)
    access(1'b1, xy(640, 0), 16'hDEAD);
    access(1'b0, xy(0, 480), 16'h0);
    access(1'b0, xy(65535, 4095), 16'h0);
    access(1'b0, xy(100, 100), 16'h0);

    // Constrained random mix
    for (int i = 0; i < 300; i++) begin
      logic [31:0] a;
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel < 6)
        a = xy(int'($urandom_range(0, 700)), int'($urandom_range(0, 520)));
      else begin
        a = $urandom();
        if (a[31:28] == 4'h8) a[31:28] = 4'h3;
      end
      access($urandom_range(0, 1) == 1, a, 16'($urandom()));
    end

    // R1 reset clears the sticky flag
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    oor_seen = 1'b0;
    chk(oor_flag == 1'b0, "R1", "oor_flag after reset", 32'(oor_flag), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule